// File: doc/BRIEF.md
# Protected Return-Address Stack

This block holds subroutine return addresses in dedicated storage inside the core, apart from the data stack in memory. Data buffer overruns therefore cannot rewrite a return address. The core changes the stack in only three ways. A call strobe pushes the link address. A return strobe pops the top entry, which is shown on the return-address output in the same cycle so that fetch can be redirected at once. A discard strobe drops the top entry without any change of control flow. The block has no port for load or store traffic, so these three strobes are the only way to change its contents.

The depth is a parameter and is finite. A push into a full stack is refused and reported as an overflow fault, and the entries already held are kept. A pop from an empty stack is reported as an underflow fault, and the output reads zero. A call and a pop in the same cycle replace the top entry.

Top module: `ret_addr_stack`

## Requirements
- R1: After a synchronous reset the stack holds no entries: `empty_o`=1, `full_o`=0, `ret_pc_o`=0, and both fault outputs are 0.
- R2: A call with the stack not full stores `call_pc_i`. From the next cycle that address is on `ret_pc_o`, combinationally and with no strobe needed.
- R3: Returns give back the stored addresses in last-in, first-out order. `ret_pc_o` shows the popped value in the cycle the return strobe is high.
- R4: A discard removes the top entry. After it, `ret_pc_o` shows the entry below, or 0 if none is left.
- R5: `full_o` is 1 exactly when DEPTH entries are held, and `empty_o` is 1 exactly when none are held.
- R6: A call alone on a full stack raises `ovf_o` in that same cycle. The stack keeps its count and every entry, including the oldest.
- R7: A return or discard on an empty stack raises `unf_o` in that same cycle. `ret_pc_o` reads 0 and the stack stays empty.
- R8: A call together with a return or discard on a non-empty stack replaces the top entry with `call_pc_i` and leaves the count unchanged. This holds when the stack is full too, and it raises no fault.
- R9: A call together with a return or discard on an empty stack raises `unf_o` for the failed pop and still stores `call_pc_i`, which leaves one entry.
- R10: Return and discard asserted together count as one pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call strobe: push `call_pc_i` |
| call_pc_i | input | ADDR_W | Link address to push |
| ret_i | input | 1 | Return strobe: pop the top entry |
| drop_i | input | 1 | Discard strobe: pop without redirect |
| ret_pc_o | output | ADDR_W | Current top entry, 0 when empty |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | DEPTH entries held |
| ovf_o | output | 1 | Push refused on a full stack (this cycle) |
| unf_o | output | 1 | Pop requested on an empty stack (this cycle) |

## Verification
The case hardest to reach is the full stack: it takes DEPTH consecutive calls before an overflow, or a replace at full depth, can be tried at all. The bench reaches it with a directed loop of distinct addresses. At full depth it tries a refused push and a replace. It then drains the whole stack so that every entry, the oldest included, is compared with the value pushed. A call and a pop together on an empty stack is the other rare case, and the vector table drives it on purpose.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Action taken by the stack in one cycle
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PUSH,
        ACT_POP,
        ACT_SWAP,
        ACT_SWAP_EMPTY,
        ACT_PUSH_REFUSED,
        ACT_POP_EMPTY
    } ras_act_e;

    // Resolve strobes against occupancy; any pop request is a single pop
    function automatic ras_act_e resolve_act(
        input logic push_req,
        input logic pop_req,
        input logic is_empty,
        input logic is_full
    );
        ras_act_e a;
        if (push_req && pop_req)
            a = is_empty ? ACT_SWAP_EMPTY : ACT_SWAP;
        else if (push_req)
            a = is_full ? ACT_PUSH_REFUSED : ACT_PUSH;
        else if (pop_req)
            a = is_empty ? ACT_POP_EMPTY : ACT_POP;
        else
            a = ACT_IDLE;
        return a;
    endfunction

    function automatic logic act_writes(input ras_act_e a);
        return (a == ACT_PUSH) || (a == ACT_SWAP) || (a == ACT_SWAP_EMPTY);
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             is_empty,
    output logic             is_full,
    output logic             ovf,
    output logic             unf
);
    import ras_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count_q, count_d;
    ras_act_e         act;

    assign is_empty = (count_q == '0);
    assign is_full  = (count_q == CNT_MAX);
    assign act      = resolve_act(push_req, pop_req, is_empty, is_full);

    always_comb begin
        count_d = count_q;
        unique case (act)
            ACT_PUSH, ACT_SWAP_EMPTY: count_d = count_q + 1'b1;
            ACT_POP:                  count_d = count_q - 1'b1;
            default:                  count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign wr_en  = act_writes(act);
    assign wr_idx = (act == ACT_SWAP) ? IDX_W'(count_q - 1'b1) : IDX_W'(count_q);
    assign rd_idx = IDX_W'(count_q - 1'b1);
    assign ovf    = (act == ACT_PUSH_REFUSED);
    assign unf    = (act == ACT_POP_EMPTY) || (act == ACT_SWAP_EMPTY);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_MAX); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && is_full) |=> is_full && $stable(count_q)); // R6
    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && is_empty) |=> is_empty); // R7
    AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !is_empty) |=> $stable(count_q)); // R8
    AST_SWAP_EMPTY_ONE: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && is_empty) |=> count_q == CNT_W'(1)); // R9
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf)); // R6
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
    end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic [ADDR_W-1:0] call_pc_i,
    input  logic              ret_i,
    input  logic              drop_i,
    output logic [ADDR_W-1:0] ret_pc_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              ovf_o,
    output logic              unf_o
);
    logic              pop_req;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [ADDR_W-1:0] top_data;

    // return and discard merge into one pop
    assign pop_req = ret_i | drop_i;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (call_i),
        .pop_req  (pop_req),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .is_empty (empty_o),
        .is_full  (full_o),
        .ovf      (ovf_o),
        .unf      (unf_o)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (call_pc_i),
        .rd_idx  (rd_idx),
        .rd_data (top_data)
    );

    assign ret_pc_o = empty_o ? '0 : top_data;

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        (call_i && !pop_req && !full_o) |=> ret_pc_o == $past(call_pc_i)); // R2
    AST_SWAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (call_i && pop_req) |=> ret_pc_o == $past(call_pc_i)); // R8
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> ret_pc_o == '0); // R7
    AST_REFUSED_TOP: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> $stable(ret_pc_o)); // R6
endmodule

// File: tb/ret_addr_stack_bench.sv
`timescale 1ns/1ps
module ret_addr_stack_bench;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              call_i = 1'b0, ret_i = 1'b0, drop_i = 1'b0;
    logic [ADDR_W-1:0] call_pc_i = '0;
    logic [ADDR_W-1:0] ret_pc_o;
    logic              empty_o, full_o, ovf_o, unf_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ret_addr_stack (
        .clk(clk), .rst(rst), .call_i(call_i), .call_pc_i(call_pc_i),
        .ret_i(ret_i), .drop_i(drop_i), .ret_pc_o(ret_pc_o),
        .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        c, r, d;
        logic [31:0] pc;
        logic [31:0] exp_pc;
        logic        ovf, unf, emp, ful;
    } vec_t;

    // Outputs expected during the cycle the vector is applied (before the edge)
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0,1'b0,1'b1,1'b0}, // R1 idle after reset
        '{4'd2,  1'b1,1'b0,1'b0, 32'h100, 32'h0,   1'b0,1'b0,1'b1,1'b0}, // R2 push A
        '{4'd2,  1'b0,1'b0,1'b0, 32'h0,   32'h100, 1'b0,1'b0,1'b0,1'b0}, // R2 top is A
        '{4'd3,  1'b1,1'b0,1'b0, 32'h200, 32'h100, 1'b0,1'b0,1'b0,1'b0}, // R3 push B
        '{4'd3,  1'b1,1'b0,1'b0, 32'h300, 32'h200, 1'b0,1'b0,1'b0,1'b0}, // R3 push C
        '{4'd3,  1'b0,1'b1,1'b0, 32'h0,   32'h300, 1'b0,1'b0,1'b0,1'b0}, // R3 ret C
        '{4'd3,  1'b0,1'b1,1'b0, 32'h0,   32'h200, 1'b0,1'b0,1'b0,1'b0}, // R3 ret B
        '{4'd4,  1'b1,1'b0,1'b0, 32'h400, 32'h100, 1'b0,1'b0,1'b0,1'b0}, // R4 push D
        '{4'd4,  1'b0,1'b0,1'b1, 32'h0,   32'h400, 1'b0,1'b0,1'b0,1'b0}, // R4 discard D
        '{4'd4,  1'b0,1'b1,1'b0, 32'h0,   32'h100, 1'b0,1'b0,1'b0,1'b0}, // R4 parent A back
        '{4'd7,  1'b0,1'b1,1'b0, 32'h0,   32'h0,   1'b0,1'b1,1'b1,1'b0}, // R7 ret on empty
        '{4'd7,  1'b0,1'b0,1'b1, 32'h0,   32'h0,   1'b0,1'b1,1'b1,1'b0}, // R7 discard on empty
        '{4'd9,  1'b1,1'b1,1'b0, 32'h500, 32'h0,   1'b0,1'b1,1'b1,1'b0}, // R9 swap on empty
        '{4'd9,  1'b0,1'b1,1'b0, 32'h0,   32'h500, 1'b0,1'b0,1'b0,1'b0}, // R9 E was kept
        '{4'd8,  1'b1,1'b0,1'b0, 32'h600, 32'h0,   1'b0,1'b0,1'b1,1'b0}, // R8 push F
        '{4'd8,  1'b1,1'b0,1'b0, 32'h650, 32'h600, 1'b0,1'b0,1'b0,1'b0}, // R8 push G
        '{4'd8,  1'b1,1'b1,1'b0, 32'h700, 32'h650, 1'b0,1'b0,1'b0,1'b0}, // R8 replace G by H
        '{4'd10, 1'b0,1'b1,1'b1, 32'h0,   32'h700, 1'b0,1'b0,1'b0,1'b0}, // R10 ret+discard
        '{4'd10, 1'b0,1'b0,1'b0, 32'h0,   32'h600, 1'b0,1'b0,1'b0,1'b0}, // R10 one pop only
        '{4'd3,  1'b0,1'b1,1'b0, 32'h0,   32'h600, 1'b0,1'b0,1'b0,1'b0}, // R3 ret F
        '{4'd5,  1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0,1'b0,1'b1,1'b0}  // R5 empty again
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive away from the rising edge, then sample the combinational outputs
    task automatic drive(input logic c, input logic r, input logic d, input logic [31:0] pc);
        @(negedge clk);
        call_i = c; ret_i = r; drop_i = d; call_pc_i = pc;
        #1;
    endtask

    task automatic idle_cycle();
        drive(1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            string tag;
            drive(VECS[v].c, VECS[v].r, VECS[v].d, VECS[v].pc);
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            check({tag, " pc"},  64'(ret_pc_o), 64'(VECS[v].exp_pc));
            check({tag, " flg"}, 64'({ovf_o, unf_o, empty_o, full_o}),
                  64'({VECS[v].ovf, VECS[v].unf, VECS[v].emp, VECS[v].ful}));
        end

        // R1: reset clears a non-empty stack
        drive(1'b1, 1'b0, 1'b0, 32'hABC);
        drive(1'b1, 1'b0, 1'b0, 32'hDEF);
        @(negedge clk); call_i = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R1 reset pc", 64'(ret_pc_o), 64'h0);
        check("R1 reset flags", 64'({ovf_o, unf_o, empty_o, full_o}), 64'b0010);

        // R5: fill to DEPTH
        for (int i = 0; i < DEPTH; i++) begin
            drive(1'b1, 1'b0, 1'b0, 32'h1000 + 32'(i) * 4);
            if (i == DEPTH - 1) check("R5 not full before last", 64'(full_o), 64'h0);
        end
        idle_cycle();
        check("R5 full", 64'({full_o, empty_o}), 64'b10);
        check("R2 top after fill", 64'(ret_pc_o), 64'(32'h1000 + 32'(DEPTH - 1) * 4));

        // R6: refused push
        drive(1'b1, 1'b0, 1'b0, 32'hDEAD);
        check("R6 ovf", 64'({ovf_o, unf_o}), 64'b10);
        idle_cycle();
        check("R6 top unchanged", 64'(ret_pc_o), 64'(32'h1000 + 32'(DEPTH - 1) * 4));
        check("R6 still full", 64'(full_o), 64'h1);

        // R8: replace at full depth, no fault
        drive(1'b1, 1'b1, 1'b0, 32'hBEEF);
        check("R8 no fault at full", 64'({ovf_o, unf_o}), 64'b00);
        idle_cycle();
        check("R8 new top", 64'(ret_pc_o), 64'hBEEF);
        check("R8 still full", 64'(full_o), 64'h1);

        // R3/R6: drain, every entry including the oldest intact
        for (int i = DEPTH - 1; i >= 0; i--) begin
            logic [31:0] e;
            e = (i == DEPTH - 1) ? 32'hBEEF : 32'h1000 + 32'(i) * 4;
            drive(1'b0, 1'b1, 1'b0, 32'h0);
            check($sformatf("R3 drain slot %0d", i), 64'(ret_pc_o), 64'(e));
        end
        idle_cycle();
        check("R5 empty after drain", 64'({full_o, empty_o}), 64'b01);
        drive(1'b0, 1'b1, 1'b0, 32'h0);
        check("R7 unf after drain", 64'({unf_o, ret_pc_o}), 64'({1'b1, 32'h0}));
        idle_cycle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule